// File: doc/BRIEF.md
# Rotating-Priority DMA Channel Arbiter

This block decides which requester wins the next system bus tenure: one of four local DMA channels, or a downstream controller connected through a cascade port. Channel requests come from active-low hardware request pins or from software request bits. A per-channel mask gates only the hardware path. A three-bit priority code selects one of eight fixed orders. The low two bits rotate the channel order, and the top bit places the cascade slot either last or first.

The arbiter raises one active-low bus request toward the system arbiter. It samples the arbiter grant and locks the winner in for the whole tenure. A local winner receives a one-hot channel select. A cascade winner is told through an active-low grant-enable output, which feeds the grant-enable input of the next controller in the daisy chain. The mask and priority code sit in a small configuration holder that is loaded by a strobe. All interfaces are plain control levels: nothing streams through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, all four channels are masked, the priority code is 000, `bus_req_n` and `gnt_en_out_n` are high, and `chan_sel` is zero.
- R2: With `cfg_prio` bit 2 at 0, the order is channels r, r+1, r+2, r+3 (mod 4), where r is `cfg_prio[1:0]`, followed by the cascade last. For example, 001 gives 1,2,3,0,C.
- R3: With `cfg_prio` bit 2 at 1, a pending cascade request beats every channel, and the channels follow in the same rotation set by `cfg_prio[1:0]`.
- R4: A set `cfg_mask` bit (bit i for channel i) blocks that channel's `dreq_n` request. A `sw_req` bit on a masked channel is still served.
- R5: While `dma_en` is low, no channel or cascade request is pending. No grant is taken, and `bus_req_n` and `gnt_en_out_n` stay high.
- R6: `dreq_n`, `sw_req`, `casc_req_n`, `casc_gnt_en_n` and `bus_gnt_n` take effect only through their values at the falling clock edge. A pulse that lies between two falling edges is never seen.
- R7: When idle, with a sampled grant, a sampled active grant-enable input and a pending request, the winner is latched on the next rising edge. `chan_sel` then stays one-hot and constant until `tenure_done` for that same channel is high at a rising edge. `tenure_done` bits for other channels have no effect.
- R8: `gnt_en_out_n` is low while idle with the cascade as current winner, and low for the whole cascade tenure. The tenure ends when a deasserted `casc_req_n` has been sampled. `chan_sel` is never nonzero at the same time.
- R9: While the sampled `casc_gnt_en_n` is high, an idle arbiter takes no grant.
- R10: `bus_req_n` is low one rising edge after a request becomes pending, or while a local tenure continues. It returns high at the first rising edge at which nothing is pending and no local tenure continues.
- R11: `cfg_mask` and `cfg_prio` are loaded on a rising edge with `cfg_load` high and otherwise hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dreq_n | input | 4 | Active-low hardware request per channel |
| sw_req | input | 4 | Software request per channel |
| cfg_load | input | 1 | Load strobe for mask and priority |
| cfg_mask | input | 4 | Mask value, 1 = hardware request blocked |
| cfg_prio | input | 3 | Priority code value |
| dma_en | input | 1 | Global enable |
| casc_req_n | input | 1 | Active-low request from downstream controller |
| casc_gnt_en_n | input | 1 | Active-low grant-enable from upstream (tie low on first) |
| bus_gnt_n | input | 1 | Active-low grant from system arbiter |
| tenure_done | input | 4 | Per-channel end of bus tenure |
| bus_req_n | output | 1 | Active-low bus request, always driven |
| chan_sel | output | 4 | One-hot select of the owning channel |
| gnt_en_out_n | output | 1 | Active-low grant-enable to downstream controller |

## Verification
The hardest situation to reach is a change that arrives in the middle of a tenure. This covers a new higher-priority request, a priority change and a completion strobe from a non-owning channel, all while the latched owner must not move. The stimulus therefore holds a grant, then reprograms the code and pulses `tenure_done` on other channels before it releases the true owner. A second hard case is a request pulse placed entirely between falling edges. The bench drives it a fraction of a cycle after a rising edge and removes it before the next falling edge. A long randomized phase, checked against a behavioural model on every clock, covers the remaining mixes of masks, codes, enables and cascade traffic.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_OWN  = 2'd1,
    ARB_CASC = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_arb_sampler.sv
// Captures every arbitration input on the falling clock edge (active-high internally).
module dma_arb_sampler #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] dreq_n,
  input  logic [N-1:0] sw_req,
  input  logic         casc_req_n,
  input  logic         casc_gnt_en_n,
  input  logic         bus_gnt_n,
  output logic [N-1:0] hw_req_s,
  output logic [N-1:0] sw_req_s,
  output logic         casc_req_s,
  output logic         gen_in_s,
  output logic         gnt_s
);
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_req_s   <= '0;
      sw_req_s   <= '0;
      casc_req_s <= 1'b0;
      gen_in_s   <= 1'b0;
      gnt_s      <= 1'b0;
    end else begin
      hw_req_s   <= ~dreq_n;
      sw_req_s   <= sw_req;
      casc_req_s <= ~casc_req_n;
      gen_in_s   <= ~casc_gnt_en_n;
      gnt_s      <= ~bus_gnt_n;
    end
  end
endmodule

// File: rtl/dma_arb_cfg.sv
// Holds mask and priority code; reset leaves everything masked with code 0.
module dma_arb_cfg #(
  parameter int N = 4,
  localparam int PW = $clog2(N) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [N-1:0]  mask_in,
  input  logic [PW-1:0] prio_in,
  output logic [N-1:0]  mask_q,
  output logic [PW-1:0] prio_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      prio_q <= '0;
    end else if (load) begin
      mask_q <= mask_in;
      prio_q <= prio_in;
    end
  end

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(mask_q) && $stable(prio_q)));
endmodule

// File: rtl/dma_arb_picker.sv
// Qualifies requests and finds the winner in the order chosen by the code.
module dma_arb_picker #(
  parameter int N = 4,
  localparam int IW = $clog2(N),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic [N-1:0]  mask,
  input  logic [PW-1:0] prio,
  input  logic [N-1:0]  hw_req,
  input  logic [N-1:0]  sw_req,
  input  logic          casc_req,
  output logic          any_pend,
  output logic          pick_casc,
  output logic [IW-1:0] pick_idx
);
  logic [N-1:0] pend_ch;
  logic         pend_casc;
  logic         ch_found;

  for (genvar g = 0; g < N; g++) begin : g_qual
    assign pend_ch[g] = dma_en & ((hw_req[g] & ~mask[g]) | sw_req[g]);
  end

  assign pend_casc = dma_en & casc_req;

  always_comb begin
    logic [IW-1:0] cand;
    ch_found = 1'b0;
    pick_idx = '0;
    for (int k = 0; k < N; k++) begin
      cand = prio[IW-1:0] + IW'(k);
      if (!ch_found && pend_ch[cand]) begin
        ch_found = 1'b1;
        pick_idx = cand;
      end
    end
  end

  assign pick_casc = pend_casc & (prio[PW-1] | ~ch_found);
  assign any_pend  = ch_found | pend_casc;

  p_pick_is_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (any_pend && !pick_casc) |-> pend_ch[pick_idx]);
  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |-> !any_pend);
endmodule

// File: rtl/dma_arb_tenure.sv
// Latches the winner on grant and holds it for the whole bus tenure.
module dma_arb_tenure #(
  parameter int N = 4,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gnt_s,
  input  logic          gen_in_s,
  input  logic          casc_req_s,
  input  logic          any_pend,
  input  logic          pick_casc,
  input  logic [IW-1:0] pick_idx,
  input  logic [N-1:0]  tenure_done,
  output logic [N-1:0]  chan_sel,
  output logic          gen_out_n,
  output logic          bus_req_n
);
  import dma_arb_pkg::*;

  arb_state_e    state;
  logic [IW-1:0] owner;
  logic          req_q;
  logic          done_hit;

  assign done_hit = tenure_done[owner];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ARB_IDLE;
      owner <= '0;
      req_q <= 1'b0;
    end else begin
      req_q <= any_pend | ((state == ARB_OWN) & ~done_hit);
      unique case (state)
        ARB_IDLE: begin
          if (gnt_s && gen_in_s && any_pend) begin
            if (pick_casc) begin
              state <= ARB_CASC;
            end else begin
              state <= ARB_OWN;
              owner <= pick_idx;
            end
          end
        end
        ARB_OWN:  if (done_hit) state <= ARB_IDLE;
        ARB_CASC: if (!casc_req_s) state <= ARB_IDLE;
        default:  state <= ARB_IDLE;
      endcase
    end
  end

  assign chan_sel  = (state == ARB_OWN) ? (N'(1) << owner) : '0;
  assign gen_out_n = ~(((state == ARB_IDLE) & gen_in_s & pick_casc) | (state == ARB_CASC));
  assign bus_req_n = ~req_q;

  p_sel_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_sel));
  p_owner_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|chan_sel) && !(|(chan_sel & tenure_done))) |=> $stable(chan_sel));
  p_casc_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !((|chan_sel) && !gen_out_n));
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ARB_IDLE) && !any_pend) |=> bus_req_n);
  p_no_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ARB_IDLE) && !gen_in_s) |=> (chan_sel == '0 && state != ARB_CASC));
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter #(
  parameter int N = 4,
  localparam int IW = $clog2(N),
  localparam int PW = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  dreq_n,
  input  logic [N-1:0]  sw_req,
  input  logic          cfg_load,
  input  logic [N-1:0]  cfg_mask,
  input  logic [PW-1:0] cfg_prio,
  input  logic          dma_en,
  input  logic          casc_req_n,
  input  logic          casc_gnt_en_n,
  input  logic          bus_gnt_n,
  input  logic [N-1:0]  tenure_done,
  output logic          bus_req_n,
  output logic [N-1:0]  chan_sel,
  output logic          gnt_en_out_n
);
  logic [N-1:0]  hw_req_s, sw_req_s, mask_q;
  logic [PW-1:0] prio_q;
  logic          casc_req_s, gen_in_s, gnt_s;
  logic          any_pend, pick_casc;
  logic [IW-1:0] pick_idx;

  dma_arb_sampler #(.N(N)) u_sampler (
    .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .sw_req(sw_req),
    .casc_req_n(casc_req_n), .casc_gnt_en_n(casc_gnt_en_n), .bus_gnt_n(bus_gnt_n),
    .hw_req_s(hw_req_s), .sw_req_s(sw_req_s), .casc_req_s(casc_req_s),
    .gen_in_s(gen_in_s), .gnt_s(gnt_s)
  );

  dma_arb_cfg #(.N(N)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load), .mask_in(cfg_mask),
    .prio_in(cfg_prio), .mask_q(mask_q), .prio_q(prio_q)
  );

  dma_arb_picker #(.N(N)) u_picker (
    .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .mask(mask_q), .prio(prio_q),
    .hw_req(hw_req_s), .sw_req(sw_req_s), .casc_req(casc_req_s),
    .any_pend(any_pend), .pick_casc(pick_casc), .pick_idx(pick_idx)
  );

  dma_arb_tenure #(.N(N)) u_tenure (
    .clk(clk), .rst_n(rst_n), .gnt_s(gnt_s), .gen_in_s(gen_in_s),
    .casc_req_s(casc_req_s), .any_pend(any_pend), .pick_casc(pick_casc),
    .pick_idx(pick_idx), .tenure_done(tenure_done), .chan_sel(chan_sel),
    .gen_out_n(gnt_en_out_n), .bus_req_n(bus_req_n)
  );
endmodule

// File: tb/dma_prio_arbiter_bench.sv
`timescale 1ns/1ps
module dma_prio_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] dreq_n = 4'hF, sw_req = 4'h0, cfg_mask = 4'hF, tenure_done = 4'h0;
  logic [2:0] cfg_prio = 3'd0;
  logic       cfg_load = 1'b0, dma_en = 1'b1, casc_req_n = 1'b1;
  logic       casc_gnt_en_n = 1'b0, bus_gnt_n = 1'b1;
  logic       bus_req_n, gnt_en_out_n;
  logic [3:0] chan_sel;

  int n_checks = 0, n_fail = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  dma_prio_arbiter u_dma_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .dreq_n(dreq_n), .sw_req(sw_req), .cfg_load(cfg_load),
    .cfg_mask(cfg_mask), .cfg_prio(cfg_prio), .dma_en(dma_en), .casc_req_n(casc_req_n),
    .casc_gnt_en_n(casc_gnt_en_n), .bus_gnt_n(bus_gnt_n), .tenure_done(tenure_done),
    .bus_req_n(bus_req_n), .chan_sel(chan_sel), .gnt_en_out_n(gnt_en_out_n)
  );

  // ---------------- behavioural reference ----------------
  bit [3:0] m_hw, m_sw, m_mask;
  bit       m_casc, m_gen, m_gnt, m_req;
  bit [2:0] m_prio;
  int       m_state, m_owner;   // state: 0 idle, 1 channel tenure, 2 cascade tenure

  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hw = 0; m_sw = 0; m_casc = 0; m_gen = 0; m_gnt = 0;
    end else begin
      m_hw = ~dreq_n; m_sw = sw_req; m_casc = !casc_req_n;
      m_gen = !casc_gnt_en_n; m_gnt = !bus_gnt_n;
    end
  end

  // returns -1 for none, 4 for cascade, else channel number
  function automatic int m_pick();
    int order[$];
    if (m_prio[2]) order.push_back(4);
    for (int k = 0; k < 4; k++) order.push_back((m_prio[1:0] + k) % 4);
    if (!m_prio[2]) order.push_back(4);
    foreach (order[i]) begin
      if (order[i] == 4) begin
        if (dma_en && m_casc) return 4;
      end else if (dma_en && ((m_hw[order[i]] && !m_mask[order[i]]) || m_sw[order[i]])) begin
        return order[i];
      end
    end
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_owner = 0; m_req = 0; m_mask = 4'hF; m_prio = 0;
    end else begin
      int w;
      bit done;
      w = m_pick();
      done = (m_state == 1) && tenure_done[m_owner];
      m_req = (w >= 0) || (m_state == 1 && !done);
      if (m_state == 0) begin
        if (m_gnt && m_gen && w >= 0) begin
          if (w == 4) m_state = 2;
          else begin m_state = 1; m_owner = w; end
        end
      end else if (m_state == 1) begin
        if (done) m_state = 0;
      end else if (!m_casc) m_state = 0;
      if (cfg_load) begin m_mask = cfg_mask; m_prio = cfg_prio; end
    end
  end

  task automatic check_eq(int act, int exp, string tag, string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    int esel;
    bit egen_n;
    esel   = (m_state == 1) ? (1 << m_owner) : 0;
    egen_n = !((m_state == 0 && m_gen && m_pick() == 4) || m_state == 2);
    check_eq(chan_sel, esel, "R7", "model chan_sel");
    check_eq(gnt_en_out_n, egen_n, "R8", "model gnt_en_out_n");
    check_eq(bus_req_n, !m_req, "R10", "model bus_req_n");
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    if (model_on) compare_model();
  endtask

  // Ends any tenure, optionally loads config, drives requests, then grants.
  task automatic round(bit load, bit [3:0] mask, bit [2:0] prio, bit [3:0] hw, bit [3:0] sw,
                       bit casc, bit en, bit gen, bit [3:0] exp_sel, bit exp_gen_n, string tag);
    bus_gnt_n = 1; tenure_done = 4'hF; casc_req_n = 1; dreq_n = 4'hF; sw_req = 0; dma_en = 1;
    casc_gnt_en_n = 0;
    step(); step();
    tenure_done = 0; cfg_load = load; cfg_mask = mask; cfg_prio = prio;
    dreq_n = ~hw; sw_req = sw; casc_req_n = !casc; dma_en = en; casc_gnt_en_n = !gen;
    step();
    cfg_load = 0; bus_gnt_n = 0;
    step();
    check_eq(chan_sel, exp_sel, tag, "chan_sel");
    check_eq(gnt_en_out_n, exp_gen_n, tag, "gnt_en_out_n");
  endtask

  initial begin
    #(5.0 * 200000);
    n_checks++; n_fail++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check_eq(bus_req_n, 1, "R1", "bus_req_n in reset");
    check_eq(chan_sel, 0, "R1", "chan_sel in reset");
    check_eq(gnt_en_out_n, 1, "R1", "gnt_en_out_n in reset");
    rst_n = 1;
    model_on = 1;
    step();
    // R1: all masked after reset, hardware requests ignored
    round(0, 4'h0, 3'd0, 4'hF, 4'h0, 0, 1, 1, 4'h0, 1, "R1");
    check_eq(bus_req_n, 1, "R1", "bus_req_n with masked requests");
    // R1: default order 0,1,2,3 (software requests pass the mask)
    round(0, 4'h0, 3'd0, 4'h0, 4'b1010, 0, 1, 1, 4'b0010, 1, "R1");
    // R2 rotations with cascade last
    round(1, 4'h0, 3'd0, 4'hF, 4'h0, 0, 1, 1, 4'b0001, 1, "R2");
    round(1, 4'h0, 3'd1, 4'hF, 4'h0, 0, 1, 1, 4'b0010, 1, "R2");
    round(1, 4'h0, 3'd2, 4'hF, 4'h0, 0, 1, 1, 4'b0100, 1, "R2");
    round(1, 4'h0, 3'd3, 4'hF, 4'h0, 1, 1, 1, 4'b1000, 1, "R2");
    round(1, 4'h0, 3'd3, 4'b0110, 4'h0, 0, 1, 1, 4'b0010, 1, "R2");
    round(1, 4'h0, 3'd1, 4'h0, 4'h0, 1, 1, 1, 4'b0000, 0, "R2");
    // R3 cascade first
    round(1, 4'h0, 3'd4, 4'hF, 4'h0, 1, 1, 1, 4'b0000, 0, "R3");
    round(1, 4'h0, 3'd6, 4'hF, 4'h0, 0, 1, 1, 4'b0100, 1, "R3");
    round(1, 4'h0, 3'd7, 4'b0101, 4'h0, 0, 1, 1, 4'b0001, 1, "R3");
    // R4 masking
    round(1, 4'b0001, 3'd0, 4'hF, 4'h0, 0, 1, 1, 4'b0010, 1, "R4");
    round(1, 4'hF, 3'd0, 4'hF, 4'b1000, 0, 1, 1, 4'b1000, 1, "R4");
    // R5 global disable
    round(1, 4'h0, 3'd4, 4'hF, 4'hF, 1, 0, 1, 4'b0000, 1, "R5");
    check_eq(bus_req_n, 1, "R5", "bus_req_n while disabled");
    // R9 grant-enable input inactive
    round(1, 4'h0, 3'd0, 4'hF, 4'h0, 1, 1, 0, 4'b0000, 1, "R9");
    // R8 lookahead while idle, grant not yet given
    round(1, 4'h0, 3'd5, 4'h0, 4'h0, 1, 1, 1, 4'b0000, 0, "R8");
    casc_req_n = 1; step(); step();
    check_eq(gnt_en_out_n, 1, "R8", "cascade tenure released");
    bus_gnt_n = 1; casc_req_n = 0; step(); step();
    check_eq(gnt_en_out_n, 0, "R8", "idle lookahead to cascade");
    check_eq(chan_sel, 0, "R8", "no local select in lookahead");
    casc_req_n = 1; step(); step();
    // R7 owner held through changes
    round(1, 4'h0, 3'd0, 4'b0001, 4'h0, 0, 1, 1, 4'b0001, 1, "R7");
    dreq_n = 4'h0; cfg_load = 1; cfg_prio = 3'd2; tenure_done = 4'b1110;
    step(); cfg_load = 0; step();
    check_eq(chan_sel, 4'b0001, "R7", "owner held mid tenure");
    tenure_done = 4'b0001; step(); tenure_done = 0; step();
    check_eq(chan_sel, 4'b0100, "R7", "next owner after release");
    // R6 / R10 sampling and request timing
    bus_gnt_n = 1; tenure_done = 4'hF; dreq_n = 4'hF; step(); step();
    tenure_done = 0; cfg_load = 1; cfg_mask = 0; cfg_prio = 0; step(); cfg_load = 0;
    check_eq(bus_req_n, 1, "R10", "released when nothing pending");
    dreq_n = 4'b1110; #1; dreq_n = 4'hF;
    step();
    check_eq(bus_req_n, 1, "R6", "pulse between falling edges unseen");
    dreq_n = 4'b1110; step();
    check_eq(bus_req_n, 0, "R10", "request raised next edge");
    dreq_n = 4'hF; step();
    check_eq(bus_req_n, 1, "R10", "request released within one clock");
    // R11 config holds without strobe
    cfg_prio = 3'd3; cfg_mask = 4'hF; step();
    round(0, 4'hF, 3'd3, 4'hF, 4'h0, 0, 1, 1, 4'b0001, 1, "R11");
    // randomized phase against the model
    bus_gnt_n = 1; tenure_done = 4'hF; step(); step();
    for (int i = 0; i < 4000; i++) begin
      dreq_n        = 4'($urandom);
      sw_req        = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      casc_req_n    = ($urandom % 3 != 0);
      casc_gnt_en_n = ($urandom % 6 == 0);
      bus_gnt_n     = ($urandom % 3 == 0);
      dma_en        = ($urandom % 8 != 0);
      tenure_done   = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
      cfg_load      = ($urandom % 10 == 0);
      cfg_mask      = 4'($urandom);
      cfg_prio      = 3'($urandom);
      step();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule